// File: doc/BRIEF.md
# Memory-Mapped Machine Timer

This block is a single-hart machine timer with one comparator. A prescaler divides the core clock into ticks. On each tick a 64-bit time counter advances by a programmable step. A 64-bit compare register is checked against the time counter with an unsigned greater-or-equal test. When the test holds, a sticky interrupt status bit is set. That status bit, ANDed with an enable bit, drives the interrupt output.

Software reaches the block through a 32-bit register port with a write strobe and a combinational read path. The time and compare values each appear as a lower word and an upper word. The block does not latch one half while the other half is being read. Software must therefore handle carries between the two reads, for example by reading upper, then lower, then upper again.

A control bit starts and stops the prescaler and the counter. Software keeps this bit low while it changes the prescale or step setting. Interrupt status is cleared in either of two ways: by writing 1 to the status bit, or by writing either compare word.

Top module: `mach_timer`

## Requirements
- R1: After reset, the configuration word reads 0x00010000 (step 1, prescale 0). Both compare words read 0xFFFFFFFF. Both time words read 0, status reads 0 and the interrupt output is low.
- R2: While active, a tick occurs on every (prescale+1)-th clock. Each tick adds the step value to the 64-bit time counter.
- R3: While the active bit (control word bit 0) is low, the prescaler count and the time value both hold. Counting resumes from the held prescaler count once the bit is set again.
- R4: In the configuration word, bits 11:0 are the prescale field and bits 23:16 are the step field. Both fields read back as written, and all other bits read 0.
- R5: Status (bit 0 of the status word) is set one clock after an unsigned 64-bit time >= compare is seen in the registers. Once set, it stays set until it is cleared.
- R6: The time counter wraps from all-ones to zero and keeps counting. A status bit that was set before the wrap stays set after it.
- R7: Writing 1 to status bit 0 clears status. Writing 0 has no effect. If time >= compare still holds, status sets again on the following clock.
- R8: A write to either compare word clears status. The next evaluation uses the newly written compare value.
- R9: The interrupt output is high exactly when both the status bit and the enable bit (bit 0 of the enable word) are set.
- R10: Both time words can be written. A time-word write takes priority over a tick in the same clock, and the tick is dropped.
- R11: Byte offsets: 0x00 control, 0x04 configuration, 0x08 time lower, 0x0C time upper, 0x10 compare lower, 0x14 compare upper, 0x18 interrupt enable, 0x1C interrupt status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Write strobe; the write takes effect at the rising clock edge |
| reg_addr | input | 5 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq_o | output | 1 | Timer interrupt, status AND enable |

## Verification
The hardest situation to reach from the ports is the wrap of the 64-bit counter while status is pending. Counting up from reset would take far too long to get there. The bench stops the counter and loads the time words just below all-ones, with a compare value of all-ones. It then enables the counter with a one-clock tick period for exactly two clocks. This carries time through all-ones to zero and shows that status was caught and stays set. The hold behaviour of the prescaler is exposed in a similar way: the bench stops it part-way through a period, and the counter then ticks early when restarted.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int DATA_W = 32;
  localparam int PRE_W  = 12;
  localparam int STEP_W = 8;

  localparam logic [4:0] OFS_CTRL   = 5'h00;
  localparam logic [4:0] OFS_CFG    = 5'h04;
  localparam logic [4:0] OFS_TIME_L = 5'h08;
  localparam logic [4:0] OFS_TIME_H = 5'h0C;
  localparam logic [4:0] OFS_CMP_L  = 5'h10;
  localparam logic [4:0] OFS_CMP_H  = 5'h14;
  localparam logic [4:0] OFS_IE     = 5'h18;
  localparam logic [4:0] OFS_STAT   = 5'h1C;

  localparam int CFG_STEP_LSB = 16;
endpackage

// File: rtl/mt_tick_gen.sv
module mt_tick_gen #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [PRE_W-1:0] prescale,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q;

  // ">=" keeps the divider from running long if prescale is lowered
  assign tick = active && (cnt_q >= prescale);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else if (active) cnt_q <= cnt_q + 1'b1;
  end

  // R3: divider holds while inactive
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(cnt_q));
  // R2: a tick restarts the divider
  p_tick_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q == '0);
endmodule

// File: rtl/mt_time_ctr.sv
module mt_time_ctr #(
  parameter int DATA_W = 32,
  parameter int STEP_W = 8,
  localparam int TIME_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [STEP_W-1:0] step,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [TIME_W-1:0] time_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) time_q[DATA_W-1:0]      <= wdata;
      if (wr_hi) time_q[TIME_W-1:DATA_W] <= wdata;
    end else if (tick) begin
      time_q <= time_q + TIME_W'(step);
    end
  end

  // R2: each tick adds the step (modulo 2^64, R6)
  p_step_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_lo && !wr_hi |=> time_q == $past(time_q) + TIME_W'($past(step)));
  // R3: no tick and no write means no change
  p_time_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !wr_lo && !wr_hi |=> $stable(time_q));
endmodule

// File: rtl/mt_irq_ctl.sv
module mt_irq_ctl #(
  parameter int DATA_W = 32,
  localparam int TIME_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_q,
  input  logic              wr_cmp_lo,
  input  logic              wr_cmp_hi,
  input  logic              w1c,
  input  logic [DATA_W-1:0] wdata,
  output logic [TIME_W-1:0] cmp_q,
  output logic              status_q
);
  logic expired;
  logic clr;

  assign expired = time_q >= cmp_q;
  assign clr     = w1c || wr_cmp_lo || wr_cmp_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '1;
    end else begin
      if (wr_cmp_lo) cmp_q[DATA_W-1:0]      <= wdata;
      if (wr_cmp_hi) cmp_q[TIME_W-1:DATA_W] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       status_q <= 1'b0;
    else if (clr)     status_q <= 1'b0;
    else if (expired) status_q <= 1'b1;
  end

  // R7/R8: any clear source drops status at the next edge
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !status_q);
  // R5: status is sticky without a clear
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status_q && !clr |=> status_q);
  // R5: a seen expiry sets status
  p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (time_q >= cmp_q) && !clr |=> status_q);
endmodule

// File: rtl/mach_timer.sv
module mach_timer
  import mt_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  localparam int TIME_W = 2 * DATA_W;

  logic              active_q;
  logic [PRE_W-1:0]  prescale_q;
  logic [STEP_W-1:0] step_q;
  logic              ie_q;
  logic              tick;
  logic [TIME_W-1:0] time_q;
  logic [TIME_W-1:0] cmp_q;
  logic              status_q;

  logic sel_ctrl, sel_cfg, sel_tl, sel_th, sel_cl, sel_ch, sel_ie, sel_st;
  assign sel_ctrl = reg_addr == ADDR_W'(OFS_CTRL);
  assign sel_cfg  = reg_addr == ADDR_W'(OFS_CFG);
  assign sel_tl   = reg_addr == ADDR_W'(OFS_TIME_L);
  assign sel_th   = reg_addr == ADDR_W'(OFS_TIME_H);
  assign sel_cl   = reg_addr == ADDR_W'(OFS_CMP_L);
  assign sel_ch   = reg_addr == ADDR_W'(OFS_CMP_H);
  assign sel_ie   = reg_addr == ADDR_W'(OFS_IE);
  assign sel_st   = reg_addr == ADDR_W'(OFS_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      prescale_q <= '0;
      step_q     <= STEP_W'(1);
      ie_q       <= 1'b0;
    end else if (reg_we) begin
      if (sel_ctrl) active_q <= reg_wdata[0];
      if (sel_cfg) begin
        prescale_q <= reg_wdata[PRE_W-1:0];
        step_q     <= reg_wdata[CFG_STEP_LSB +: STEP_W];
      end
      if (sel_ie) ie_q <= reg_wdata[0];
    end
  end

  mt_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active_q),
    .prescale (prescale_q),
    .tick     (tick)
  );

  mt_time_ctr #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_time (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .step   (step_q),
    .wr_lo  (reg_we && sel_tl),
    .wr_hi  (reg_we && sel_th),
    .wdata  (reg_wdata),
    .time_q (time_q)
  );

  mt_irq_ctl #(.DATA_W(DATA_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .time_q    (time_q),
    .wr_cmp_lo (reg_we && sel_cl),
    .wr_cmp_hi (reg_we && sel_ch),
    .w1c       (reg_we && sel_st && reg_wdata[0]),
    .wdata     (reg_wdata),
    .cmp_q     (cmp_q),
    .status_q  (status_q)
  );

  assign irq_o = status_q && ie_q;

  always_comb begin
    reg_rdata = '0;
    unique case (1'b1)
      sel_ctrl: reg_rdata[0] = active_q;
      sel_cfg: begin
        reg_rdata[PRE_W-1:0]              = prescale_q;
        reg_rdata[CFG_STEP_LSB +: STEP_W] = step_q;
      end
      sel_tl:  reg_rdata = time_q[DATA_W-1:0];
      sel_th:  reg_rdata = time_q[TIME_W-1:DATA_W];
      sel_cl:  reg_rdata = cmp_q[DATA_W-1:0];
      sel_ch:  reg_rdata = cmp_q[TIME_W-1:DATA_W];
      sel_ie:  reg_rdata[0] = ie_q;
      sel_st:  reg_rdata[0] = status_q;
      default: reg_rdata = '0;
    endcase
  end

  // R9: the interrupt never rises without its enable
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ie_q && status_q);
  // R3: inactive timer leaves time alone unless software writes it
  p_inactive_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q && !(reg_we && (sel_tl || sel_th)) |=> $stable(time_q));
endmodule

// File: tb/sim_mach_timer.sv
module sim_mach_timer;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mach_timer u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o)
  );

  // {time, compare, expected status}
  localparam logic [128:0] VEC [8] = '{
    {64'd5, 64'd5, 1'b1},
    {64'd4, 64'd5, 1'b0},
    {64'h1_0000_0000, 64'h0_FFFF_FFFF, 1'b1},
    {64'h0_FFFF_FFFF, 64'h1_0000_0000, 1'b0},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1},
    {64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1},
    {64'h0, 64'h0, 1'b1}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk_rd(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, {32'd0, v}, {32'd0, exp});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values (offsets per R11)
    chk_rd("R1 cfg reset", 5'h04, 32'h0001_0000);
    chk_rd("R1 cmp lo reset", 5'h10, 32'hFFFF_FFFF);
    chk_rd("R1 cmp hi reset", 5'h14, 32'hFFFF_FFFF);
    chk_rd("R1 time lo reset", 5'h08, 32'h0);
    chk_rd("R1 status reset", 5'h1C, 32'h0);
    check("R1 irq reset", {63'd0, irq_o}, 64'd0);
    rst_n = 1'b1;
    idle(2);
    chk_rd("R1 status after release", 5'h1C, 32'h0);

    // R5 table of unsigned compares; R11 map, R10 time writes
    foreach (VEC[i]) begin
      wr(5'h08, VEC[i][128:97]);
      wr(5'h0C, VEC[i][128:97] == 0 ? VEC[i][128:97] : VEC[i][128:97]);
      wr(5'h08, VEC[i][96:65]);
      wr(5'h0C, VEC[i][128:97]);
      wr(5'h10, VEC[i][32:1]);
      wr(5'h14, VEC[i][64:33]);
      idle(1);
      chk_rd($sformatf("R5 vec%0d status", i), 5'h1C, {31'd0, VEC[i][0]});
      chk_rd($sformatf("R10 vec%0d time lo", i), 5'h08, VEC[i][96:65]);
    end

    // R4 configuration layout
    wr(5'h04, 32'hFFFF_FFFF);
    chk_rd("R4 cfg mask", 5'h04, 32'h00FF_0FFF);
    // R2 prescale 3, step 1
    wr(5'h04, 32'h0001_0003);
    wr(5'h08, 32'h0);
    wr(5'h0C, 32'h0);
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h00, 32'h1);
    idle(9);
    wr(5'h00, 32'h0);
    chk_rd("R2 two ticks in ten clocks", 5'h08, 32'd2);
    idle(20);
    chk_rd("R3 time holds while inactive", 5'h08, 32'd2);
    // R3 divider held at 2: restart ticks after two clocks; step 3 (R2)
    wr(5'h04, 32'h0003_0003);
    wr(5'h00, 32'h1);
    idle(1);
    wr(5'h00, 32'h0);
    chk_rd("R3 divider resumes from held count", 5'h08, 32'd5);

    // R6 wrap with pending status
    wr(5'h04, 32'h0001_0000);
    wr(5'h08, 32'hFFFF_FFFE);
    wr(5'h0C, 32'hFFFF_FFFF);
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h14, 32'hFFFF_FFFF);
    idle(1);
    chk_rd("R5 below max no status", 5'h1C, 32'h0);
    wr(5'h00, 32'h1);
    idle(1);
    wr(5'h00, 32'h0);
    chk_rd("R6 time lo wrapped", 5'h08, 32'h0);
    chk_rd("R6 time hi wrapped", 5'h0C, 32'h0);
    chk_rd("R6 status kept after wrap", 5'h1C, 32'h1);

    // R9 gating, R7 write-1 clear
    check("R9 irq low without enable", {63'd0, irq_o}, 64'd0);
    wr(5'h18, 32'h1);
    check("R9 irq high with enable", {63'd0, irq_o}, 64'd1);
    wr(5'h1C, 32'h0);
    chk_rd("R7 write 0 no effect", 5'h1C, 32'h1);
    wr(5'h1C, 32'h1);
    chk_rd("R7 write 1 clears", 5'h1C, 32'h0);
    check("R9 irq drops with status", {63'd0, irq_o}, 64'd0);
    idle(2);
    chk_rd("R7 stays clear when not expired", 5'h1C, 32'h0);

    // R7 re-set after clear
    wr(5'h08, 32'd10);
    wr(5'h10, 32'd5);
    wr(5'h14, 32'd0);
    idle(1);
    chk_rd("R5 set when time above compare", 5'h1C, 32'h1);
    wr(5'h1C, 32'h1);
    chk_rd("R7 cleared on clear edge", 5'h1C, 32'h0);
    idle(1);
    chk_rd("R7 sets again next clock", 5'h1C, 32'h1);
    // R8 compare write clears, judged on new value
    wr(5'h10, 32'd20);
    chk_rd("R8 cmp lo write clears", 5'h1C, 32'h0);
    idle(2);
    chk_rd("R8 new compare not reached", 5'h1C, 32'h0);
    wr(5'h10, 32'd10);
    idle(1);
    chk_rd("R8 equal compare sets", 5'h1C, 32'h1);
    wr(5'h14, 32'd0);
    chk_rd("R8 cmp hi write clears", 5'h1C, 32'h0);

    // R10 write wins over tick
    wr(5'h00, 32'h1);
    wr(5'h08, 32'd100);
    wr(5'h00, 32'h0);
    chk_rd("R10 write then one tick", 5'h08, 32'd101);

    finish_run();
  end
endmodule